// File: doc/BRIEF.md
# Wakeup Timer Real-Time Clock

This block is a small memory-mapped real-time clock whose main job is to raise a periodic wakeup event. A counting tick is taken from one of four clock-enable inputs and can be slowed by two prescaler stages that are enabled separately: one divides by 512 and one divides by 32. The stages cascade, so the overall ratio is 1, 32, 512 or 16384. A wakeup counter counts prescaled ticks. When the count since the last value load reaches the programmed nonzero value, the counter sets a sticky flag and starts over, so the event repeats with that period.

Software reaches the block through a flat 32-bit register port. A write is one cycle with the write strobe high. Read data is registered and appears one cycle after the address. A new wakeup value does not take effect at once. It passes through a visible busy phase that models the transfer into the counting domain, and writes made during that phase are dropped. The clock-source and divider fields are frozen while the counter runs. To reconfigure, software stops the counter, writes the new fields, then starts it again. The interrupt is a level output that stays high until the flag is cleared.

Top module: `rtc_wake_top`

## Requirements
- R1: After synchronous reset, the control, status and wakeup-value registers all read 0 and `irq_o` is low.
- R2: Control register at byte offset 0x04 has these bits: 31 = run, 15 = wakeup enable, 14 = interrupt enable, 13:12 = clock-source select, 11 = ÷512 stage enable, 10 = ÷32 stage enable. All other bits read 0.
- R3: A control write updates the source-select and divider bits only if the run bit held 0 before the write. In a write made while running, those bits are ignored, but the run and enable bits still update.
- R4: The prescaler input advances only on cycles where the selected `src_tick` bit is 1 and run is 1. A source that never ticks, or a stopped counter, produces no wakeup.
- R5: With src_tick always high, the prescaled tick rate is one per 1, 32, 512 or 16384 cycles for divider enables none, ÷32 only, ÷512 only, and both.
- R6: With wakeup enabled and a nonzero value N in effect, the flag sets on every N-th prescaled tick. The first setting comes N ticks after the value takes effect, and the timing repeats with period N.
- R7: A wakeup value of 0 disarms the timer, so the flag is never set.
- R8: A write to the wakeup-value register at byte offset 0x10 is accepted only while status bit 17 (busy) is 0. Busy then reads 1 for exactly 3 ticks of the selected source, after which the new value is in effect, reads back at 0x10, and restarts the elapsed count. Writes made while busy is 1 are ignored.
- R9: Status register at byte offset 0x08 has the wakeup flag at bit 13. A write of 1 to bit 13 clears the flag, and a write of 0 leaves it unchanged. If a wakeup setting and a clear happen in the same cycle, the setting wins.
- R10: `irq_o` is high exactly when the flag, the interrupt enable and the wakeup enable are all 1.
- R11: Read data reflects the address presented in the previous cycle. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for previous cycle's address |
| src_tick | input | 4 | Clock-enable pulses from the four counting sources |
| irq_o | output | 1 | Level wakeup interrupt |

## Verification
The assertions assume that `src_tick` bits are single-cycle enables sampled on `clk` and that software follows the stop–configure–start order. They also assume the busy flag is only left early through a tick of the selected source. This means a source that never ticks leaves a pending value stuck, so the stimulus writes new wakeup values only while a live source is selected. The stimulus drives every input on the falling edge. Every measured wakeup period is taken between two successive flag rises, with the flag cleared in between, so the unknown prescaler phase at start never enters an expected value.

// File: rtl/rtc_wake_pkg.sv
package rtc_wake_pkg;
  // byte offsets of the registers
  localparam int unsigned OFF_CTRL = 'h04;
  localparam int unsigned OFF_STAT = 'h08;
  localparam int unsigned OFF_WAKE = 'h10;

  // control bit positions
  localparam int unsigned CB_RUN   = 31;
  localparam int unsigned CB_WKEN  = 15;
  localparam int unsigned CB_WKIE  = 14;
  localparam int unsigned CB_SEL   = 12;
  localparam int unsigned CB_DVA   = 11;
  localparam int unsigned CB_DVB   = 10;

  // status bit positions
  localparam int unsigned SB_BUSY  = 17;
  localparam int unsigned SB_FLAG  = 13;

  localparam int unsigned SEL_W    = 2;

  typedef struct packed {
    logic             run;
    logic             wk_en;
    logic             wk_ie;
    logic [SEL_W-1:0] sel;
    logic             dva;
    logic             dvb;
  } ctrl_t;

  function automatic logic [31:0] ctrl_word(ctrl_t c);
    logic [31:0] w;
    w = '0;
    w[CB_RUN]              = c.run;
    w[CB_WKEN]             = c.wk_en;
    w[CB_WKIE]             = c.wk_ie;
    w[CB_SEL +: SEL_W]     = c.sel;
    w[CB_DVA]              = c.dva;
    w[CB_DVB]              = c.dvb;
    return w;
  endfunction
endpackage

// File: rtl/rtc_div_stage.sv
module rtc_div_stage #(
  parameter int unsigned RATIO = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic en_i,
  input  logic tick_i,
  output logic tick_o
);
  localparam int unsigned CW = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q <= '0;
    end else if (en_i && tick_i) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign tick_o = en_i ? (tick_i && (cnt_q == LAST)) : tick_i;

  AST_STAGE_NEEDS_INPUT: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> tick_i); // R5
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned RATIO_A = 512,
  parameter int unsigned RATIO_B = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic tick_i,
  input  logic en_a_i,
  input  logic en_b_i,
  output logic tick_o
);
  localparam int unsigned N_STG = 2;

  logic [N_STG:0]   chain;
  logic [N_STG-1:0] stg_en;

  assign chain[0] = tick_i & run_i;
  assign stg_en   = {en_b_i, en_a_i};

  for (genvar g = 0; g < N_STG; g++) begin : g_stage
    localparam int unsigned R = (g == 0) ? RATIO_A : RATIO_B;
    rtc_div_stage #(.RATIO(R)) u_stage (
      .clk    (clk),
      .rst    (rst),
      .run_i  (run_i),
      .en_i   (stg_en[g]),
      .tick_i (chain[g]),
      .tick_o (chain[g+1])
    );
  end

  assign tick_o = chain[N_STG];
endmodule

// File: rtl/rtc_wake_sync.sv
module rtc_wake_sync #(
  parameter int unsigned VAL_W    = 32,
  parameter int unsigned SYNC_LEN = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic [VAL_W-1:0] wdata_i,
  input  logic             tick_i,
  output logic             busy_o,
  output logic             load_o,
  output logic [VAL_W-1:0] value_o
);
  localparam int unsigned CW = (SYNC_LEN > 1) ? $clog2(SYNC_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(SYNC_LEN - 1);

  logic             busy_q;
  logic [CW-1:0]    cnt_q;
  logic [VAL_W-1:0] pend_q;
  logic             accept;

  assign accept = wr_i && !busy_q;
  assign load_o = busy_q && tick_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      pend_q <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      pend_q <= wdata_i;
    end else if (load_o) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q && tick_i) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign busy_o  = busy_q;
  assign value_o = pend_q;

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !tick_i) |=> busy_q); // R8
  AST_BUSY_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(wr_i)); // R8
  AST_PENDING_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (busy_q && wr_i) |=> $stable(pend_q)); // R8
endmodule

// File: rtl/rtc_wake_timer.sv
module rtc_wake_timer #(
  parameter int unsigned VAL_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [VAL_W-1:0] load_val_i,
  input  logic             step_i,
  input  logic             arm_en_i,
  output logic             hit_o,
  output logic [VAL_W-1:0] wake_val_o
);
  logic [VAL_W-1:0] wake_val_q;
  logic [VAL_W-1:0] elapsed_q;
  logic             armed;

  assign armed = arm_en_i && (wake_val_q != '0);
  assign hit_o = step_i && armed && (elapsed_q == wake_val_q - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      wake_val_q <= '0;
      elapsed_q  <= '0;
    end else if (load_i) begin
      wake_val_q <= load_val_i;
      elapsed_q  <= '0;
    end else if (step_i && armed) begin
      elapsed_q  <= hit_o ? '0 : elapsed_q + 1'b1;
    end
  end

  assign wake_val_o = wake_val_q;

  AST_VALUE_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    !$stable(wake_val_q) |-> $past(load_i)); // R8
  AST_ELAPSED_BELOW_TARGET: assert property (@(posedge clk) disable iff (rst)
    (wake_val_q != '0) |-> (elapsed_q < wake_val_q)); // R6
  AST_NO_HIT_WHEN_ZERO: assert property (@(posedge clk) disable iff (rst)
    (wake_val_q == '0) |-> !hit_o); // R7
endmodule

// File: rtl/rtc_wake_top.sv
module rtc_wake_top
  import rtc_wake_pkg::*;
#(
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned VAL_W    = 32,
  parameter int unsigned RATIO_A  = 512,
  parameter int unsigned RATIO_B  = 32,
  parameter int unsigned SYNC_LEN = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [3:0]        src_tick,
  output logic              irq_o
);
  localparam int unsigned N_SRC = 1 << SEL_W;

  ctrl_t            ctrl_q;
  logic             flag_q;
  logic [31:0]      rdata_q;

  logic             wr_ctrl, wr_stat, wr_wake;
  logic             clr_flag;
  logic             tick_sel;
  logic             pre_tick;
  logic             busy;
  logic             load;
  logic [VAL_W-1:0] pend_val;
  logic [VAL_W-1:0] wake_val;
  logic             hit;
  logic [N_SRC-1:0] src_vec;

  assign src_vec  = src_tick;
  assign wr_ctrl  = bus_we && (bus_addr == ADDR_W'(OFF_CTRL));
  assign wr_stat  = bus_we && (bus_addr == ADDR_W'(OFF_STAT));
  assign wr_wake  = bus_we && (bus_addr == ADDR_W'(OFF_WAKE));
  assign clr_flag = wr_stat && bus_wdata[SB_FLAG];
  assign tick_sel = src_vec[ctrl_q.sel];

  // control register: configuration fields only move while stopped
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q.run   <= bus_wdata[CB_RUN];
      ctrl_q.wk_en <= bus_wdata[CB_WKEN];
      ctrl_q.wk_ie <= bus_wdata[CB_WKIE];
      if (!ctrl_q.run) begin
        ctrl_q.sel <= bus_wdata[CB_SEL +: SEL_W];
        ctrl_q.dva <= bus_wdata[CB_DVA];
        ctrl_q.dvb <= bus_wdata[CB_DVB];
      end
    end
  end

  rtc_prescaler #(.RATIO_A(RATIO_A), .RATIO_B(RATIO_B)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .run_i  (ctrl_q.run),
    .tick_i (tick_sel),
    .en_a_i (ctrl_q.dva),
    .en_b_i (ctrl_q.dvb),
    .tick_o (pre_tick)
  );

  rtc_wake_sync #(.VAL_W(VAL_W), .SYNC_LEN(SYNC_LEN)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .wr_i    (wr_wake),
    .wdata_i (bus_wdata[VAL_W-1:0]),
    .tick_i  (tick_sel),
    .busy_o  (busy),
    .load_o  (load),
    .value_o (pend_val)
  );

  rtc_wake_timer #(.VAL_W(VAL_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load),
    .load_val_i (pend_val),
    .step_i     (pre_tick),
    .arm_en_i   (ctrl_q.wk_en),
    .hit_o      (hit),
    .wake_val_o (wake_val)
  );

  // sticky wakeup flag, setting beats clearing
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
    end else if (hit) begin
      flag_q <= 1'b1;
    end else if (clr_flag) begin
      flag_q <= 1'b0;
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= '0;
      if (bus_addr == ADDR_W'(OFF_CTRL)) begin
        rdata_q <= ctrl_word(ctrl_q);
      end else if (bus_addr == ADDR_W'(OFF_STAT)) begin
        rdata_q[SB_BUSY] <= busy;
        rdata_q[SB_FLAG] <= flag_q;
      end else if (bus_addr == ADDR_W'(OFF_WAKE)) begin
        rdata_q <= 32'(wake_val);
      end
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_o     = flag_q & ctrl_q.wk_ie & ctrl_q.wk_en;

  AST_CFG_FROZEN_WHILE_RUN: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.run && $past(ctrl_q.run)) |-> $stable({ctrl_q.sel, ctrl_q.dva, ctrl_q.dvb})); // R3
  AST_FLAG_FALL_NEEDS_W1C: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_q) |-> $past(wr_stat && bus_wdata[SB_FLAG])); // R9
  AST_FLAG_RISE_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(ctrl_q.wk_en && pre_tick)); // R6
  AST_STOPPED_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q.run |-> !pre_tick); // R4
endmodule

// File: tb/test_rtc_wake_top.sv
module test_rtc_wake_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  src_tick = 4'b0001;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  int now = 0;
  logic [1:0] phase = '0;

  localparam logic [31:0] A_CTRL = 32'h04, A_STAT = 32'h08, A_WAKE = 32'h10;
  localparam logic [31:0] RUN = 32'h8000_0000, WKEN = 32'h8000, WKIE = 32'h4000;
  localparam logic [31:0] DVA = 32'h800, DVB = 32'h400, FLAGB = 32'h2000, BUSYB = 32'h2_0000;

  always #10 clk = ~clk;

  rtc_wake_top i_rtc_wake_top (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .src_tick  (src_tick),
    .irq_o     (irq_o)
  );

  // source patterns: 0 always, 1 every other cycle, 2 never, 3 every fourth
  always @(negedge clk) begin
    phase       <= phase + 2'd1;
    src_tick[1] <= ~src_tick[1];
    src_tick[3] <= (phase == 2'd3);
  end

  always @(posedge clk) now <= now + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard
  logic [31:0] exp_q[$];
  logic [31:0] msk_q[$];
  string       tag_q[$];
  logic        rd_req = 1'b0;
  logic        mon_valid = 1'b0;

  always @(posedge clk) mon_valid <= rd_req;

  always @(negedge clk) begin
    if (mon_valid && exp_q.size() > 0) begin
      logic [31:0] e, m;
      string t;
      e = exp_q.pop_front();
      m = msk_q.pop_front();
      t = tag_q.pop_front();
      chk(t, bus_rdata & m, e & m);
    end
  end

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    bus_addr  = a[4:0];
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, input logic [31:0] e, input logic [31:0] m, input string t);
    bus_addr = a[4:0];
    exp_q.push_back(e);
    msk_q.push_back(m);
    tag_q.push_back(t);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic wait_irq(output int t, input int limit);
    int n = 0;
    while (!irq_o && n < limit) begin
      @(negedge clk);
      n++;
    end
    t = irq_o ? now : -1;
  endtask

  task automatic period(output int p, input int limit);
    int t1, t2;
    wr(A_STAT, FLAGB);
    wait_irq(t1, limit);
    wr(A_STAT, FLAGB);
    wait_irq(t2, limit);
    p = (t1 < 0 || t2 < 0) ? -1 : t2 - t1;
  endtask

  task automatic reconfig(input logic [31:0] cfg);
    wr(A_CTRL, WKEN | WKIE);
    wr(A_CTRL, cfg);
    wr(A_CTRL, cfg | RUN);
  endtask

  initial begin
    #(20 * 190000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=done", now);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int p;
    int n;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // reset state
    rd(A_CTRL, 0, '1, "R1 ctrl after reset");
    rd(A_STAT, 0, '1, "R1 status after reset");
    rd(A_WAKE, 0, '1, "R1 wake value after reset");
    chk("R1 irq after reset", 32'(irq_o), 0);
    rd(32'h0C, 0, '1, "R11 unmapped offset reads zero");

    // field layout while stopped
    wr(A_CTRL, 32'h0000_3000 | DVA | DVB | WKEN | WKIE | 32'h0000_0101);
    rd(A_CTRL, 32'h0000_FC00, '1, "R2 control fields readback");
    wr(A_CTRL, 0);
    rd(A_CTRL, 0, '1, "R2 control cleared while stopped");

    // first wakeup latency: 3 busy ticks + 5 prescaled ticks
    wr(A_CTRL, RUN | WKEN | WKIE);
    wr(A_WAKE, 5);
    n = 0;
    while (!irq_o && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk("R6 R8 first wakeup latency", n, 8);
    period(p, 100);
    chk("R6 periodic wakeup N=5", p, 5);

    // write-one-to-clear
    wr(A_STAT, 0);
    chk("R9 writing 0 keeps flag", 32'(irq_o), 1);
    wr(A_STAT, FLAGB);
    chk("R9 writing 1 clears flag", 32'(irq_o), 0);

    // busy handshake and ignored write
    wr(A_WAKE, 7);
    wr(A_WAKE, 9);
    rd(A_STAT, BUSYB, BUSYB, "R8 busy visible after write");
    repeat (4) @(negedge clk);
    rd(A_WAKE, 7, '1, "R8 write during busy ignored");
    rd(A_STAT, 0, BUSYB, "R8 busy cleared after 3 ticks");
    period(p, 100);
    chk("R8 new value in effect N=7", p, 7);

    // disarm with zero
    wr(A_WAKE, 0);
    repeat (6) @(negedge clk);
    wr(A_STAT, FLAGB);
    repeat (60) @(negedge clk);
    chk("R7 zero value gives no wakeup", 32'(irq_o), 0);
    rd(A_STAT, 0, FLAGB, "R7 flag stays clear when disarmed");

    // interrupt gating
    wr(A_CTRL, RUN | WKEN);
    wr(A_WAKE, 4);
    repeat (30) @(negedge clk);
    chk("R10 irq low with interrupt enable off", 32'(irq_o), 0);
    rd(A_STAT, FLAGB, FLAGB, "R10 flag set while irq masked");
    wr(A_CTRL, RUN | WKEN | WKIE);
    chk("R10 irq high once enabled", 32'(irq_o), 1);
    wr(A_CTRL, RUN | WKIE);
    chk("R10 irq low with wakeup enable off", 32'(irq_o), 0);
    wr(A_CTRL, RUN | WKEN | WKIE);

    // source select
    reconfig(WKEN | WKIE | 32'h1000);
    wr(A_WAKE, 5);
    repeat (10) @(negedge clk);
    period(p, 200);
    chk("R4 source 1 period", p, 10);
    wr(A_CTRL, RUN | WKEN | WKIE | 32'h3000 | DVB);
    rd(A_CTRL, RUN | WKEN | WKIE | 32'h1000, '1, "R3 fields frozen while running");
    period(p, 200);
    chk("R3 period unchanged after frozen write", p, 10);
    reconfig(WKEN | WKIE | 32'h3000);
    period(p, 200);
    chk("R4 source 3 period", p, 20);
    reconfig(WKEN | WKIE | 32'h2000);
    wr(A_STAT, FLAGB);
    repeat (200) @(negedge clk);
    chk("R4 silent source gives no wakeup", 32'(irq_o), 0);
    wr(A_CTRL, WKEN | WKIE);
    wr(A_CTRL, WKEN | WKIE);
    wr(A_STAT, FLAGB);
    repeat (100) @(negedge clk);
    chk("R4 stopped counter gives no wakeup", 32'(irq_o), 0);

    // divide ratios
    reconfig(WKEN | WKIE | DVB);
    wr(A_WAKE, 4);
    repeat (10) @(negedge clk);
    period(p, 2000);
    chk("R5 divide by 32", p, 128);
    reconfig(WKEN | WKIE | DVA);
    wr(A_WAKE, 3);
    repeat (10) @(negedge clk);
    period(p, 5000);
    chk("R5 divide by 512", p, 1536);
    reconfig(WKEN | WKIE | DVA | DVB);
    wr(A_WAKE, 1);
    repeat (10) @(negedge clk);
    period(p, 40000);
    chk("R5 divide by 16384", p, 16384);

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule